// File: doc/BRIEF.md
# Scaled Single-to-Half Precision Narrowing Converter

This block takes a stream of 32-bit IEEE single-precision words and turns each one into a 16-bit IEEE half-precision word. Before it rounds, it multiplies the value by a power of two. It does this by adding a signed scale exponent, sampled together with each word, to the unpacked exponent. A training datapath can therefore apply a loss scale, such as 2^3 or 2^15, as it narrows gradients. The scale costs no multiplier and gives no rounding other than the final narrowing.

Each result comes with four flags:
- overflow, when the scaled magnitude rounds past the largest finite half value;
- underflow, when a nonzero input rounds to zero;
- denormal, when the result is subnormal;
- special, when the input was an infinity or a NaN.

Software or a neighbouring block can count these flags to tell whether the chosen scale loses values at either end of the half-precision range. Both sides use a valid/ready handshake. The datapath is two register stages deep. It accepts one word per cycle while the consumer is ready, and it freezes under backpressure.

Top module: `scaled_narrow_cvt`

## Requirements
- R1: A result is packed with the sign in bit 15, the biased exponent (bias 15) in bits 14:10 and the fraction in bits 9:0. A value that is exactly representable as a normal half converts without error and with all flags low.
- R2: The result equals the input multiplied by 2^s, where s is the two's-complement scale input sampled with the word. Both positive and negative s are applied before rounding.
- R3: Rounding is to nearest, with ties going to the even fraction. A carry out of the fraction increments the exponent.
- R4: A finite input whose scaled magnitude rounds above 65504 gives an infinity of the input's sign (exponent 31, fraction 0) with the overflow flag set. A result of exactly 65504 is encoded as 0x7BFF and raises no flag.
- R5: A scaled magnitude that rounds into the range 2^-24 up to, but not including, 2^-14 gives exponent field 0 and a nonzero fraction, with the denormal flag set. A value that rounds up to 2^-14 becomes the smallest normal (0x0400) with no flag.
- R6: A nonzero finite input that rounds below 2^-24 gives a zero of the input's sign with the underflow flag set. A zero input gives a zero of the same sign with no flag.
- R7: An infinite input gives an infinity of the same sign, whatever the scale. A NaN input gives a quiet NaN (exponent 31, fraction bit 9 set, other fraction bits 0) with the input's sign. Both set the special flag. At most one of the four flags is set on any result.
- R8: Subnormal single-precision inputs are normalised before scaling, so a large positive scale can bring them back into the half range.
- R9: A word accepted on a rising clock edge appears on the output after the next rising edge. While the output is ready, the input is ready every cycle.
- R10: While out_valid is high and out_ready is low, the output word and flags hold steady and no accepted word is lost or duplicated. Results leave in acceptance order.
- R11: While reset is asserted, and on the cycle after it, out_valid is low. After reset, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_word | input | 32 | Single-precision value |
| in_scale | input | SCALE_W | Signed power-of-two scale exponent |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_half | output | 16 | Half-precision result |
| out_ovf | output | 1 | Result saturated to infinity |
| out_unf | output | 1 | Nonzero input flushed to zero |
| out_den | output | 1 | Result is subnormal |
| out_special | output | 1 | Input was infinity or NaN |

## Verification
The directed patterns cover several distinct paths:
- Exact normals check the field packing.
- One mantissa converted under several scales, positive and negative, separates a correct exponent offset from one that is off by one or sign-mixed.
- Three rounding patterns (exact tie with an even fraction, tie with an odd fraction, just above half) each pick out one term of the round-to-nearest-even condition.
- An all-ones mantissa exercises the carry into the exponent.

At the range edges, 65504 against 65520 sits on the overflow boundary. Scales of -15, -24 and -25 with mantissas 1.0 and 1.5 walk the subnormal shift down to the last-bit tie. A value just under 2^-14 rounds back into the normal range. Zeros, infinities, quiet and signalling NaNs, and subnormal single-precision inputs separate the classification paths. A back-to-back stream and a stalled consumer test throughput, ordering and the hold behaviour.

// File: rtl/snc_pkg.sv
package snc_pkg;

    localparam int F32_EXP_W  = 8;
    localparam int F32_FRAC_W = 23;
    localparam int F32_BIAS   = 127;
    localparam int F16_EXP_W  = 5;
    localparam int F16_FRAC_W = 10;
    localparam int F16_BIAS   = 15;
    localparam int MANT_W     = F32_FRAC_W + 1;
    localparam int ESUM_W     = 12;   // holds any unbiased exponent plus a scale up to 10 bits
    localparam int LZ_W       = 5;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } val_class_e;

    // Decoded, scaled operand between the two pipeline stages.
    typedef struct packed {
        logic                     sign;
        val_class_e               cls;
        logic [MANT_W-1:0]        mant;   // leading one at the top bit for CLS_NUM
        logic signed [ESUM_W-1:0] exp;    // unbiased exponent after scaling
    } dec_word_t;

    // Narrowed result with its flags.
    typedef struct packed {
        logic [15:0] half;
        logic        ovf;
        logic        unf;
        logic        den;
        logic        special;
    } half_res_t;

    // Number of zeros above the highest set bit of a single-precision fraction.
    function automatic logic [LZ_W-1:0] frac_lead_zeros(input logic [F32_FRAC_W-1:0] f);
        logic [LZ_W-1:0] cnt;
        cnt = LZ_W'(F32_FRAC_W);
        for (int i = 0; i < F32_FRAC_W; i++) begin
            if (f[i]) cnt = LZ_W'(F32_FRAC_W - 1 - i);
        end
        return cnt;
    endfunction

    // Round-to-nearest-even increment from lsb, guard and sticky.
    function automatic logic rne_inc(input logic lsb, input logic guard, input logic sticky);
        return guard & (sticky | lsb);
    endfunction

endpackage

// File: rtl/snc_unpack.sv
module snc_unpack
    import snc_pkg::*;
#(
    parameter int SCALE_W = 8
) (
    input  logic [31:0]              word,
    input  logic signed [SCALE_W-1:0] scale,
    output dec_word_t                dec
);

    localparam int EXT_W = ESUM_W - SCALE_W;

    logic [F32_EXP_W-1:0]       exp_f;
    logic [F32_FRAC_W-1:0]      frac_f;
    logic [LZ_W-1:0]            lz;
    logic signed [ESUM_W-1:0]   scale_ext;
    logic signed [ESUM_W-1:0]   exp_raw;

    assign exp_f     = word[30:23];
    assign frac_f    = word[22:0];
    assign lz        = frac_lead_zeros(frac_f);
    assign scale_ext = {{EXT_W{scale[SCALE_W-1]}}, scale};

    always_comb begin
        dec.sign = word[31];
        dec.cls  = CLS_NUM;
        dec.mant = '0;
        exp_raw  = '0;
        if (exp_f == '1) begin
            dec.cls = (frac_f != '0) ? CLS_NAN : CLS_INF;
        end else if (exp_f == '0) begin
            if (frac_f == '0) begin
                dec.cls = CLS_ZERO;
            end else begin
                // subnormal input: shift the leading one up to the hidden-bit position
                dec.mant = MANT_W'({1'b0, frac_f} << (lz + LZ_W'(1)));
                exp_raw  = -ESUM_W'(F32_BIAS) - $signed({{(ESUM_W-LZ_W){1'b0}}, lz});
            end
        end else begin
            dec.mant = {1'b1, frac_f};
            exp_raw  = $signed({{(ESUM_W-F32_EXP_W){1'b0}}, exp_f}) - ESUM_W'(F32_BIAS);
        end
        dec.exp = (dec.cls == CLS_NUM) ? exp_raw + scale_ext : '0;
    end

endmodule

// File: rtl/snc_narrow.sv
module snc_narrow
    import snc_pkg::*;
(
    input  dec_word_t d,
    output half_res_t r
);

    localparam int EMIN     = 1 - F16_BIAS;                      // -14
    localparam int GUARD_LO = MANT_W - F16_FRAC_W - 1;           // 13 discarded bits on the normal path
    localparam int SHIFT_MX = MANT_W + 1;                        // shift that clears every bit
    localparam logic signed [ESUM_W-1:0] EMIN_S = ESUM_W'(EMIN);

    // normal path
    logic                      n_inc;
    logic [F16_FRAC_W:0]       n_sum;
    logic signed [ESUM_W-1:0]  n_ebias;

    // subnormal path
    logic signed [ESUM_W-1:0]  s_under;
    logic [LZ_W-1:0]           s_sh;
    logic [F16_FRAC_W-1:0]     s_q;
    logic                      s_guard;
    logic [MANT_W-1:0]         s_mask;
    logic                      s_sticky;
    logic                      s_inc;
    logic [F16_FRAC_W:0]       s_qr;

    always_comb begin
        n_inc   = rne_inc(d.mant[GUARD_LO], d.mant[GUARD_LO-1], |d.mant[GUARD_LO-2:0]);
        n_sum   = {1'b0, d.mant[MANT_W-2:GUARD_LO]} + (F16_FRAC_W+1)'(n_inc);
        n_ebias = d.exp + ESUM_W'(F16_BIAS) + ESUM_W'(n_sum[F16_FRAC_W]);
    end

    always_comb begin
        s_under  = EMIN_S - d.exp;
        s_sh     = (s_under > ESUM_W'(SHIFT_MX - GUARD_LO)) ? LZ_W'(SHIFT_MX)
                                                           : LZ_W'(s_under + ESUM_W'(GUARD_LO));
        s_q      = F16_FRAC_W'(d.mant >> s_sh);
        s_guard  = |(MANT_W'(d.mant >> (s_sh - LZ_W'(1))) & MANT_W'(1));
        s_mask   = MANT_W'((25'd1 << (s_sh - LZ_W'(1))) - 25'd1);
        s_sticky = |(d.mant & s_mask);
        s_inc    = rne_inc(s_q[0], s_guard, s_sticky);
        s_qr     = {1'b0, s_q} + (F16_FRAC_W+1)'(s_inc);
    end

    always_comb begin
        r = '0;
        unique case (d.cls)
            CLS_ZERO: r.half = {d.sign, 15'd0};
            CLS_INF: begin
                r.half    = {d.sign, {F16_EXP_W{1'b1}}, {F16_FRAC_W{1'b0}}};
                r.special = 1'b1;
            end
            CLS_NAN: begin
                r.half    = {d.sign, {F16_EXP_W{1'b1}}, 1'b1, {(F16_FRAC_W-1){1'b0}}};
                r.special = 1'b1;
            end
            default: begin
                if (d.exp >= EMIN_S) begin
                    if (n_ebias >= ESUM_W'((1 << F16_EXP_W) - 1)) begin
                        r.half = {d.sign, {F16_EXP_W{1'b1}}, {F16_FRAC_W{1'b0}}};
                        r.ovf  = 1'b1;
                    end else begin
                        r.half = {d.sign, F16_EXP_W'(n_ebias), n_sum[F16_FRAC_W-1:0]};
                    end
                end else begin
                    // a carry out of the subnormal fraction lands in the exponent lsb
                    r.half = {d.sign, {(F16_EXP_W-1){1'b0}}, s_qr};
                    r.unf  = (s_qr == '0);
                    r.den  = (s_qr != '0) && !s_qr[F16_FRAC_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/snc_pipe_stage.sv
module snc_pipe_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);

    assign up_ready = !dn_valid || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (up_ready && up_valid) begin
            dn_data <= up_data;
        end
    end

endmodule

// File: rtl/scaled_narrow_cvt.sv
module scaled_narrow_cvt
    import snc_pkg::*;
#(
    parameter int SCALE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [31:0]               in_word,
    input  logic signed [SCALE_W-1:0] in_scale,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [15:0]               out_half,
    output logic                      out_ovf,
    output logic                      out_unf,
    output logic                      out_den,
    output logic                      out_special
);

    localparam int DEC_W = $bits(dec_word_t);
    localparam int RES_W = $bits(half_res_t);

    dec_word_t dec_in;
    dec_word_t dec_q;
    half_res_t res_d;
    half_res_t res_q;
    logic      mid_valid;
    logic      mid_ready;

    snc_unpack #(.SCALE_W(SCALE_W)) u_unpack (
        .word  (in_word),
        .scale (in_scale),
        .dec   (dec_in)
    );

    snc_pipe_stage #(.W(DEC_W)) u_stage_dec (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (dec_in),
        .dn_valid (mid_valid),
        .dn_ready (mid_ready),
        .dn_data  (dec_q)
    );

    snc_narrow u_narrow (
        .d (dec_q),
        .r (res_d)
    );

    snc_pipe_stage #(.W(RES_W)) u_stage_res (
        .clk      (clk),
        .rst      (rst),
        .up_valid (mid_valid),
        .up_ready (mid_ready),
        .up_data  (res_d),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (res_q)
    );

    assign out_half    = res_q.half;
    assign out_ovf     = res_q.ovf;
    assign out_unf     = res_q.unf;
    assign out_den     = res_q.den;
    assign out_special = res_q.special;

    // R11: nothing valid right after reset
    p_idle_after_reset_r11: assert property (@(posedge clk) rst |=> !out_valid);

    // R10: a stalled result holds
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_half) && $stable(out_ovf)
                                       && $stable(out_unf) && $stable(out_den) && $stable(out_special)));

    // R9: a ready consumer never throttles the input
    p_full_rate_r9: assert property (@(posedge clk) disable iff (rst) out_ready |-> in_ready);

    // R4: overflow always carries the infinity code
    p_ovf_is_inf_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ovf) |-> (out_half[14:0] == 15'h7C00));

    // R6: underflow always carries a zero magnitude
    p_unf_is_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unf) |-> (out_half[14:0] == 15'h0000));

    // R5: denormal flag matches a subnormal code
    p_den_code_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_den) |-> (out_half[14:10] == 5'd0 && out_half[9:0] != 10'd0));

    // R7: special inputs give the all-ones exponent; flags are exclusive
    p_special_code_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_special) |-> (out_half[14:10] == 5'h1F));
    p_flags_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_ovf, out_unf, out_den, out_special}));

endmodule

// File: tb/scaled_narrow_cvt_tb_top.sv
module scaled_narrow_cvt_tb_top;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_word = '0;
    logic signed [7:0] in_scale = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [15:0]       out_half;
    logic              out_ovf, out_unf, out_den, out_special;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    scaled_narrow_cvt #(.SCALE_W(8)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_scale(in_scale),
        .out_valid(out_valid), .out_ready(out_ready), .out_half(out_half),
        .out_ovf(out_ovf), .out_unf(out_unf), .out_den(out_den), .out_special(out_special)
    );

    // flags vector order: {ovf, unf, den, special}
    task automatic check_out(input string req, input logic [15:0] exp_h, input logic [3:0] exp_f);
        logic [3:0] got_f;
        got_f = {out_ovf, out_unf, out_den, out_special};
        checks++;
        if (!out_valid || out_half !== exp_h || got_f !== exp_f) begin
            errors++;
            $display("FAIL %s: valid %b half %h flags %b, expected valid 1 half %h flags %b",
                     req, out_valid, out_half, got_f, exp_h, exp_f);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, want);
        end
    endtask

    // one word through an empty pipe; result sampled on the negedge after the second rising edge
    task automatic conv(input string req, input logic [31:0] w, input int s,
                        input logic [15:0] exp_h, input logic [3:0] exp_f);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_scale = 8'(s);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_out(req, exp_h, exp_f);
    endtask

    task automatic t_reset();
        check_bit("R11 out_valid in reset", out_valid, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R11 out_valid after reset", out_valid, 1'b0);
        check_bit("R11 in_ready after reset", in_ready, 1'b1);
    endtask

    task automatic t_normal();
        conv("R1 one", 32'h3F800000, 0, 16'h3C00, 4'b0000);
        conv("R1 minus 2.5", 32'hC0200000, 0, 16'hC100, 4'b0000);
    endtask

    task automatic t_scale();
        conv("R2 x8", 32'h3F800000, 3, 16'h4800, 4'b0000);
        conv("R2 x32768", 32'h3F800000, 15, 16'h7800, 4'b0000);
        conv("R2 3 x 1/4", 32'h40400000, -2, 16'h3A00, 4'b0000);
        conv("R2 2^100 x 2^-100", 32'h71800000, -100, 16'h3C00, 4'b0000);
    endtask

    task automatic t_round();
        conv("R3 tie even stays", 32'h3F801000, 0, 16'h3C00, 4'b0000);
        conv("R3 tie odd rounds up", 32'h3F803000, 0, 16'h3C02, 4'b0000);
        conv("R3 above half", 32'h3F801008, 0, 16'h3C01, 4'b0000);
        conv("R3 carry into exponent", 32'h3FFFFFFF, 0, 16'h4000, 4'b0000);
    endtask

    task automatic t_overflow();
        conv("R4 max finite", 32'h477FE000, 0, 16'h7BFF, 4'b0000);
        conv("R4 rounds past max", 32'h477FF000, 0, 16'h7C00, 4'b1000);
        conv("R4 scaled 65536", 32'h3F800000, 16, 16'h7C00, 4'b1000);
        conv("R4 negative overflow", 32'hBF800000, 20, 16'hFC00, 4'b1000);
    endtask

    task automatic t_denorm();
        conv("R5 2^-15", 32'h3F800000, -15, 16'h0200, 4'b0010);
        conv("R5 2^-24", 32'h3F800000, -24, 16'h0001, 4'b0010);
        conv("R5 1.5 x 2^-25", 32'h3FC00000, -25, 16'h0001, 4'b0010);
        conv("R5 rounds up to min normal", 32'h387FE000, 0, 16'h0400, 4'b0000);
    endtask

    task automatic t_underflow();
        conv("R6 2^-25 tie to zero", 32'h3F800000, -25, 16'h0000, 4'b0100);
        conv("R6 negative tie to zero", 32'hBF800000, -25, 16'h8000, 4'b0100);
        conv("R6 far below", 32'h3F800000, -40, 16'h0000, 4'b0100);
        conv("R6 plus zero", 32'h00000000, 5, 16'h0000, 4'b0000);
        conv("R6 minus zero", 32'h80000000, -5, 16'h8000, 4'b0000);
    endtask

    task automatic t_special();
        conv("R7 plus inf", 32'h7F800000, -30, 16'h7C00, 4'b0001);
        conv("R7 minus inf", 32'hFF800000, 0, 16'hFC00, 4'b0001);
        conv("R7 quiet nan", 32'h7FC00001, 0, 16'h7E00, 4'b0001);
        conv("R7 signalling nan", 32'hFF800001, 10, 16'hFE00, 4'b0001);
    endtask

    task automatic t_f32_denorm();
        conv("R8 2^-127 x 2^127", 32'h00400000, 127, 16'h3C00, 4'b0000);
        conv("R8 2^-149 x 2^125", 32'h00000001, 125, 16'h0001, 4'b0010);
        conv("R8 unscaled subnormal", 32'h00000001, 0, 16'h0000, 4'b0100);
    endtask

    task automatic t_stream();
        logic [31:0] w[4] = '{32'h3F800000, 32'hC0200000, 32'h3F803000, 32'h477FE000};
        logic [15:0] e[4] = '{16'h3C00, 16'hC100, 16'h3C02, 16'h7BFF};
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c >= 2) check_out("R9 stream order", e[c-2], 4'b0000);
            if (c < 4) begin
                check_bit("R9 in_ready while streaming", in_ready, 1'b1);
                in_valid = 1'b1;
                in_word  = w[c];
                in_scale = 8'sd0;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check_bit("R9 pipe drained", out_valid, 1'b0);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1; in_word = 32'h3F800000; in_scale = 8'sd0;
        @(negedge clk);
        in_word = 32'hC0200000;
        @(negedge clk);
        in_word = 32'h40400000; in_scale = -8'sd2;
        @(negedge clk);
        check_bit("R10 input stalled", in_ready, 1'b0);
        check_out("R10 head held", 16'h3C00, 4'b0000);
        @(negedge clk);
        check_bit("R10 input still stalled", in_ready, 1'b0);
        check_out("R10 head still held", 16'h3C00, 4'b0000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R10 second result", 16'hC100, 4'b0000);
        @(negedge clk);
        check_out("R10 third result", 16'h3A00, 4'b0000);
        @(negedge clk);
        check_bit("R10 no duplicate", out_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal();
        t_scale();
        t_round();
        t_overflow();
        t_denorm();
        t_underflow();
        t_special();
        t_f32_denorm();
        t_stream();
        t_backpressure();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule